// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers eight level-sensitive PCI interrupt request lines, numbered 0 to 7 (A to H), and one power-management system control interrupt (SCI) onto two sets of interrupt controller inputs. The first set is the 16 legacy PIC inputs. Each PIRQ has a routing byte that names one PIC input, and a disable flag that removes that PIRQ from the legacy side. A PIC input is high when any enabled PIRQ routed to it is high. The second set is the 24 APIC global system interrupt lines. On that side each PIRQ owns line 16+n, whatever its routing byte holds.

The SCI goes to one of five destinations, chosen by a 3-bit select field. It is stored in a flop, so a change on the SCI input reaches the outputs one clock after it is sampled. A small byte-wide register port holds the eight routing bytes and the select field. A combinational side function maps a device slot and its INTx pin to the PIRQ that carries that device's interrupt.

The PIC and APIC outputs are combinational from the stored registers and the current PIRQ levels. A register write takes effect at the clock edge that samples it. Reset is synchronous and active high.

Top module: `pirq_router`

## Requirements
- R1: While reset is held and after it is released, every routing byte reads 0x80 (PIRQ disabled, IRQ field 0) and the SCI select reads 0. With these values every PIC output is low, whatever the PIRQ levels are.
- R2: The routing bytes for PIRQ 0..3 sit at addresses 0x0..0x3 and those for PIRQ 4..7 at 0x8..0xB. The SCI select occupies bits 2:0 of address 0x4. A routing byte reads {disable flag in bit 7, 000, IRQ in bits 3:0}, and writes to bits 6:4 are dropped. Bits 7:3 at address 0x4 and every other address read zero. A write is visible only after the clock edge that samples it.
- R3: PIC output k is the OR of the levels of all PIRQs whose disable flag is clear and whose IRQ field equals k.
- R4: A PIRQ whose disable flag is set drives no PIC output.
- R5: APIC line 16+n follows PIRQ n, and the routing bytes have no effect on it.
- R6: The SCI select encodings are 0→9, 1→10, 2→11, 4→20 and 5→21. Encodings 3, 6 and 7 are reserved, and with any of them the SCI drives no output. APIC lines 0..15 are driven by nothing but the SCI.
- R7: The stored SCI level is ORed onto the selected APIC line. It is also ORed onto the PIC output of the same number, but only when that number is below 16.
- R8: The stored SCI level is loaded from the SCI input on each clock edge and cleared by reset. The outputs follow the stored level, not the input.
- R9: The slot map returns ((slot + pin) mod 4) + 4 for every slot except slot 30. For slot 30 it returns 4 + pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_lvl | input | 8 | PIRQ levels, bit n is PIRQ n |
| sci_lvl | input | 1 | System control interrupt level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from cfg_addr) |
| dev_slot | input | 5 | Device slot number for the pin map |
| dev_pin | input | 2 | Device INTx pin (0 = INTA) |
| dev_pirq | output | 3 | PIRQ number that carries the device interrupt |
| pic_irq | output | 16 | Legacy PIC input levels |
| apic_gsi | output | 24 | APIC global system interrupt levels |

## Verification
The assertions assume that PIRQ levels, the SCI input and register writes arrive as clean, synchronous values sampled at the rising edge, and that the select field and the routing bytes change only through the write port. The bench drives every input on the falling edge and samples half a cycle later. Each write is a one-cycle strobe, and the reserved SCI encodings are applied only through ordinary writes. This way the comparisons against the bench's own routing model never straddle an edge.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int PIRQ_N = 8;
  localparam int PIC_N  = 16;
  localparam int GSI_N  = PIC_N + PIRQ_N;
  localparam int IRQ_W  = 4;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 4;
  localparam int NUM_W  = $clog2(GSI_N);

  localparam logic [ADDR_W-1:0] ADDR_GRP_LO = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_SCI    = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_GRP_HI = 4'h8;
  localparam logic [SEL_W-1:0]  SCI_SEL_RST = 3'd0;

  typedef struct packed {
    logic             off;
    logic [IRQ_W-1:0] irq;
  } route_t;

  localparam route_t ROUTE_RST = '{off: 1'b1, irq: '0};

  function automatic logic [7:0] route_to_byte(route_t r);
    return {r.off, 3'b000, r.irq};
  endfunction

  // returns {valid, destination number}
  function automatic logic [NUM_W:0] sci_target(logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return {1'b1, NUM_W'(9)};
      3'd1:    return {1'b1, NUM_W'(10)};
      3'd2:    return {1'b1, NUM_W'(11)};
      3'd4:    return {1'b1, NUM_W'(20)};
      3'd5:    return {1'b1, NUM_W'(21)};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int N = PIRQ_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              sci_in,
  output route_t [N-1:0]    routes,
  output logic [SEL_W-1:0]  sci_sel,
  output logic              sci_q
);
  localparam int GRP = N / 2;

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_route
    localparam logic [ADDR_W-1:0] MY_ADDR =
      (i < GRP) ? ADDR_W'(int'(ADDR_GRP_LO) + i)
                : ADDR_W'(int'(ADDR_GRP_HI) + i - GRP);
    assign hit[i] = (addr == MY_ADDR);
    always_ff @(posedge clk) begin
      if (rst)                routes[i] <= ROUTE_RST;
      else if (we && hit[i])  routes[i] <= '{off: wdata[7], irq: wdata[IRQ_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sci_sel <= SCI_SEL_RST;
      sci_q   <= 1'b0;
    end else begin
      if (we && addr == ADDR_SCI) sci_sel <= wdata[SEL_W-1:0];
      sci_q <= sci_in;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) rdata = route_to_byte(routes[i]);
    if (addr == ADDR_SCI) rdata = {{(8-SEL_W){1'b0}}, sci_sel};
  end

  // R2: without a write strobe the stored routing state stays put
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(routes) && $stable(sci_sel)));
endmodule

// File: rtl/pirq_sci_decode.sv
module pirq_sci_decode
  import pirq_router_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             sci_q,
  output logic [PIC_N-1:0] sci_pic,
  output logic [GSI_N-1:0] sci_gsi
);
  logic [NUM_W:0] tgt;
  assign tgt = sci_target(sel);

  always_comb begin
    sci_gsi = '0;
    sci_pic = '0;
    if (tgt[NUM_W] && sci_q) begin
      sci_gsi[tgt[NUM_W-1:0]] = 1'b1;
      if (int'(tgt[NUM_W-1:0]) < PIC_N) sci_pic[tgt[IRQ_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/pirq_pic_mux.sv
module pirq_pic_mux
  import pirq_router_pkg::*;
#(
  parameter int N = PIRQ_N
) (
  input  logic             clk,
  input  logic             rst,
  input  route_t [N-1:0]   routes,
  input  logic [N-1:0]     lvl,
  input  logic [PIC_N-1:0] sci_pic,
  output logic [PIC_N-1:0] pic_out
);
  logic [N-1:0] live;

  for (genvar n = 0; n < N; n++) begin : g_live
    assign live[n] = lvl[n] & ~routes[n].off;
  end

  for (genvar k = 0; k < PIC_N; k++) begin : g_line
    always_comb begin
      pic_out[k] = sci_pic[k];
      for (int n = 0; n < N; n++)
        if (live[n] && routes[n].irq == IRQ_W'(k)) pic_out[k] = 1'b1;
    end
  end

  // R4: a raised PIC line needs an enabled high PIRQ or the SCI behind it
  a_r4_pic_source: assert property (@(posedge clk) disable iff (rst)
    (|pic_out) |-> ((|live) || (|sci_pic)));
endmodule

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
  parameter int SLOT_W      = 5,
  parameter int PIN_W       = 2,
  parameter int BRIDGE_SLOT = 30
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [PIN_W-1:0]  pin,
  output logic [2:0]        pirq
);
  logic [PIN_W-1:0] mix;
  assign mix = slot[PIN_W-1:0] + pin;

  always_comb begin
    if (slot == SLOT_W'(BRIDGE_SLOT)) pirq = {1'b1, pin};
    else                              pirq = {1'b1, mix};
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        pirq_lvl,
  input  logic              sci_lvl,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [4:0]        dev_slot,
  input  logic [1:0]        dev_pin,
  output logic [2:0]        dev_pirq,
  output logic [15:0]       pic_irq,
  output logic [23:0]       apic_gsi
);
  route_t [PIRQ_N-1:0] routes;
  logic [SEL_W-1:0]    sci_sel;
  logic                sci_q;
  logic [PIC_N-1:0]    sci_pic;
  logic [GSI_N-1:0]    sci_gsi;

  pirq_route_regs #(.N(PIRQ_N)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sci_in(sci_lvl), .routes(routes),
    .sci_sel(sci_sel), .sci_q(sci_q)
  );

  pirq_sci_decode u_sci (
    .sel(sci_sel), .sci_q(sci_q), .sci_pic(sci_pic), .sci_gsi(sci_gsi)
  );

  pirq_pic_mux #(.N(PIRQ_N)) u_mux (
    .clk(clk), .rst(rst), .routes(routes), .lvl(pirq_lvl),
    .sci_pic(sci_pic), .pic_out(pic_irq)
  );

  pirq_slot_map u_map (.slot(dev_slot), .pin(dev_pin), .pirq(dev_pirq));

  assign apic_gsi = {pirq_lvl, {PIC_N{1'b0}}} | sci_gsi;

  // R5: every high PIRQ shows on its own APIC line
  a_r5_apic_follow: assert property (@(posedge clk) disable iff (rst)
    (apic_gsi[GSI_N-1:PIC_N] & pirq_lvl) == pirq_lvl);
  // R6: the low APIC lines carry at most the single SCI destination
  a_r6_low_gsi: assert property (@(posedge clk) disable iff (rst)
    $onehot0(apic_gsi[PIC_N-1:0]));
  // R7: an SCI below 16 on the APIC side is mirrored on the PIC side
  a_r7_sci_mirror: assert property (@(posedge clk) disable iff (rst)
    (apic_gsi[PIC_N-1:0] & ~pic_irq) == '0);
endmodule

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [4:0]  dev_slot = '0;
  logic [1:0]  dev_pin = '0;
  logic [2:0]  dev_pirq;
  logic [15:0] pic_irq;
  logic [23:0] apic_gsi;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rb [8];

  always #4 clk = ~clk;

  pirq_router u_dut (.*);

  localparam logic [7:0] PATS [12] = '{
    8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h08,
    8'h10, 8'h20, 8'h40, 8'h80, 8'hFF, 8'h5A
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [15:0] model_pic(input logic [7:0] lvl);
    logic [15:0] r = '0;
    for (int n = 0; n < 8; n++)
      if (lvl[n] && !rb[n][7]) r[rb[n][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic int sci_num(input int sel);
    case (sel)
      0: return 9;  1: return 10; 2: return 11;
      4: return 20; 5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [3:0] route_addr(input int n);
    return (n < 4) ? 4'(n) : 4'(8 + n - 4);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    // R1: reset state
    pirq_lvl = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      rd(route_addr(n), d);
      chk("R1 route reset", 32'(d), 32'h80);
    end
    rd(4'h4, d);
    chk("R1 sci select reset", 32'(d), 32'h0);
    chk("R1 pic quiet after reset", 32'(pic_irq), 32'h0);
    chk("R5 apic follows with routes disabled", 32'(apic_gsi), 32'hFF0000);

    // R2: write timing, reserved bits, unmapped reads
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'h1; cfg_wdata = 8'hF5;
    #1 chk("R2 write not visible before edge", 32'(cfg_rdata), 32'h80);
    @(negedge clk);
    cfg_we = 1'b0;
    rd(4'h1, d);
    chk("R2 reserved bits dropped", 32'(d), 32'h85);
    wr(4'h4, 8'hFF);
    rd(4'h4, d);
    chk("R2 sci select field width", 32'(d), 32'h07);
    wr(4'h4, 8'h00);
    rd(4'hF, d);
    chk("R2 unmapped reads zero", 32'(d), 32'h0);
    rd(4'h5, d);
    chk("R2 gap address reads zero", 32'(d), 32'h0);

    // R3/R4/R5: routing table walk
    rb[0] = 8'h05; rb[1] = 8'h05; rb[2] = 8'h0A; rb[3] = 8'h8A;
    rb[4] = 8'h0F; rb[5] = 8'h00; rb[6] = 8'h09; rb[7] = 8'h03;
    for (int n = 0; n < 8; n++) wr(route_addr(n), rb[n]);
    rd(4'hB, d);
    chk("R2 upper group address", 32'(d), 32'h03);
    foreach (PATS[i]) begin
      @(negedge clk);
      pirq_lvl = PATS[i];
      #1;
      chk("R3 R4 pic wired-or", 32'(pic_irq), 32'(model_pic(PATS[i])));
      chk("R5 apic per-pirq line", 32'(apic_gsi), {8'h0, PATS[i], 16'h0});
    end
    // R4: only the disabled PIRQ 3 high
    @(negedge clk); pirq_lvl = 8'h08;
    #1 chk("R4 disabled pirq silent", 32'(pic_irq), 32'h0);
    pirq_lvl = 8'h00;

    // R6/R7: each SCI select encoding
    for (int s = 0; s < 8; s++) begin
      int t;
      logic [23:0] eg;
      wr(4'h4, 8'(s));
      sci_lvl = 1'b1;
      @(negedge clk);
      #1;
      t = sci_num(s);
      eg = (t < 0) ? 24'h0 : (24'h1 << t);
      chk("R6 R7 sci apic line", 32'(apic_gsi), 32'(eg));
      chk("R6 R7 sci pic line", 32'(pic_irq), 32'(eg[15:0]));
      sci_lvl = 1'b0;
      @(negedge clk);
    end

    // R8: SCI goes through the stored level
    wr(4'h4, 8'h00);
    @(negedge clk);
    sci_lvl = 1'b1;
    #1 chk("R8 sci not yet stored", 32'(pic_irq), 32'h0);
    @(negedge clk);
    #1 chk("R8 sci stored after edge", 32'(pic_irq), 32'h200);
    // SCI shares PIC 9 with PIRQ 6
    pirq_lvl = 8'h40;
    #1 chk("R7 sci ored with pirq on pic 9", 32'(pic_irq), 32'h200);

    // R9: slot map
    begin
      int sl [7] = '{0, 3, 7, 30, 30, 31, 29};
      int pn [7] = '{0, 2, 3, 0, 3, 1, 2};
      int ex [7] = '{4, 5, 6, 4, 7, 4, 7};
      for (int i = 0; i < 7; i++) begin
        dev_slot = 5'(sl[i]); dev_pin = 2'(pn[i]);
        #1 chk("R9 slot map", 32'(dev_pirq), 32'(ex[i]));
      end
    end

    // R1/R8: reset mid-run with SCI and PIRQs high
    pirq_lvl = 8'hFF;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    rd(4'h0, d);
    chk("R1 reset restores route", 32'(d), 32'h80);
    rd(4'hA, d);
    chk("R1 reset restores upper route", 32'(d), 32'h80);
    chk("R8 reset clears stored sci", 32'(pic_irq), 32'h0);
    chk("R5 apic during reset", 32'(apic_gsi), 32'hFF0000);
    @(negedge clk); rst = 1'b0; sci_lvl = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule